// File: doc/BRIEF.md
# Request-Driven DMA Stream Engine

This block is one DMA stream. It copies a programmed number of items from a source address to a destination address over a single-beat valid/ready bus. Each item takes two beats: a read at the source, then a write of the captured value at the destination. In the two peripheral directions, a request line paces the transfer. A channel-select field picks that line from a bank of peripheral request inputs, and each request moves exactly one item. In memory-to-memory direction the stream runs back to back and needs no request.

Software sets the configuration ports and pulses `start`. The stream latches the configuration and runs. It raises sticky half-transfer, transfer-complete and transfer-error flags, which are cleared by write-one-to-clear. In circular mode the stream reloads its addresses and count at the end of each round and keeps going until `halt` is pulsed. In normal mode it stops by itself when the last item is done. A bus error stops the stream at once.

Top module: `dmaStream`

## Requirements
- R1: After reset, `busy`, all three flags and `busValid` are 0, and `busValid` is never high while `busy` is 0.
- R2: A `start` pulse latches the configuration and sets `busy` when `cfgCount` is non-zero. A `start` pulse with `cfgCount` equal to 0 is ignored: `busy` stays 0 and no bus beat occurs. Direction codes in `cfgDir` are 0 peripheral-to-memory, 1 memory-to-peripheral and 2 memory-to-memory.
- R3: Each item is a read beat (`busWrite`=0) at the current source address, followed by a write beat (`busWrite`=1) of the read value at the current destination address. In directions 0 and 1, each item needs one request on `periphReq[cfgChanSel]`, and the other request lines have no effect. In direction 2, items run without any request.
- R4: Each clock cycle in which the selected request line is high while the stream is busy counts as one request. Requests that arrive during a transfer are kept pending (up to 15) and are serviced later, so none is lost.
- R5: The width code `cfgWidth` is 0 for byte, 1 for half word and 2 for word. The source address and the destination address each advance by 1, 2 or 4 after every item when their own increment enable (`cfgSrcInc`, `cfgDstInc`) is set. When the enable is clear, the same address is reused for every item.
- R6: The written data is the read data masked to its low 8, 16 or 32 bits according to the width code, and `busSize` carries the latched width code on every beat.
- R7: For a count N of 2 or more, `halfFlag` is set when floor(N/2) items of a round have completed, and not before.
- R8: `doneFlag` is set when all N items of a round have completed. In normal mode, `busy` then returns to 0.
- R9: In circular mode (`cfgCircular`=1), the addresses and the count reload after the last item, and `busy` stays 1 so the next round starts with no new `start`. A `halt` pulse while the stream waits for a request makes `busy` 0.
- R10: A beat completing with `busErr`=1 sets `errFlag`, drops `busy` and `busValid` on the next cycle, and stops the transfer. When the error hits a read beat, that item is not written. No further beat occurs until the next `start`.
- R11: The flags are sticky until cleared by a pulse on `clearFlags`, where bit 0 clears `halfFlag`, bit 1 clears `doneFlag` and bit 2 clears `errFlag`. A flag whose bit is 0 is kept.
- R12: While `busValid` is high and `busReady` is low, `busValid`, `busWrite`, `busAddr` and `busWdata` hold steady.
- R13: `busPriority` shows the 2-bit priority latched at `start` for the whole transfer (3 very high, 2 high, 1 medium, 0 low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch configuration and enable the stream |
| halt | input | 1 | Clear the stream enable |
| cfgSrcAddr | input | ADDR_W | Source start address |
| cfgDstAddr | input | ADDR_W | Destination start address |
| cfgCount | input | CNT_W | Items per round |
| cfgWidth | input | 2 | Item width code |
| cfgDir | input | 2 | Direction code |
| cfgSrcInc | input | 1 | Source address increment enable |
| cfgDstInc | input | 1 | Destination address increment enable |
| cfgCircular | input | 1 | Circular mode |
| cfgChanSel | input | CH_W | Request line select |
| cfgPriority | input | 2 | Stream priority level |
| periphReq | input | NUM_CH | Peripheral request lines |
| clearFlags | input | 3 | Write-one-to-clear for half, done, error |
| busValid | output | 1 | Bus beat valid |
| busWrite | output | 1 | Beat is a write |
| busAddr | output | ADDR_W | Beat address |
| busWdata | output | DATA_W | Write data |
| busSize | output | 2 | Beat width code |
| busPriority | output | 2 | Latched priority |
| busReady | input | 1 | Beat accepted |
| busRdata | input | DATA_W | Read data |
| busErr | input | 1 | Beat error, valid with busReady |
| busy | output | 1 | Stream active |
| halfFlag | output | 1 | Half-transfer flag |
| doneFlag | output | 1 | Transfer-complete flag |
| errFlag | output | 1 | Transfer-error flag |

## Verification
The bench targets requests that arrive back to back while a beat stalls. A stream that dropped them would write fewer items than were requested. It pulses request lines other than the selected one; a faulty channel select would start reads with no valid request. Per-item address and data checks cover every width and increment setting, which catches a wrong step or a missing mask. It counts the exact item at which the half flag rises, runs circular rounds past the wrap to expose a missing reload, and injects a read error mid-transfer. A stream that did not stop at that error would write the failed item or keep issuing beats afterwards.

// File: rtl/dmaPkg.sv
package dmaPkg;

  // direction codes
  localparam logic [1:0] DIR_P2M = 2'd0;
  localparam logic [1:0] DIR_M2P = 2'd1;
  localparam logic [1:0] DIR_M2M = 2'd2;

  // width codes
  localparam logic [1:0] WID_BYTE = 2'd0;
  localparam logic [1:0] WID_HALF = 2'd1;
  localparam logic [1:0] WID_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE
  } streamStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch configuration
    logic capture;  // latch read data
    logic advance;  // item done: step addresses, count down
    logic reload;   // circular wrap
    logic useDst;   // drive destination address on bus
  } ctlStrobesT;

endpackage

// File: rtl/dmaReqMux.sv
module dmaReqMux #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] reqLines,
  input  logic [CH_W-1:0]   chanSel,
  output logic              reqSel
);

  logic [NUM_CH-1:0] hitVec;

  // one-hot decode of the channel select, gated by its request line
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
    assign hitVec[gi] = reqLines[gi] && (chanSel == CH_W'(gi));
  end

  assign reqSel = |hitVec;

endmodule

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobesT        strb,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [1:0]        cfgWidth,
  input  logic [1:0]        cfgDir,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic              cfgCircular,
  input  logic [CH_W-1:0]   cfgChanSel,
  input  logic [1:0]        cfgPriority,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [1:0]        busSize,
  output logic [1:0]        busPriority,
  output logic [1:0]        latDir,
  output logic              latCirc,
  output logic [CH_W-1:0]   latChan,
  output logic              lastItem,
  output logic              halfHit
);

  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [ADDR_W-1:0] baseSrc, baseDst, curSrc, curDst;
  logic [CNT_W-1:0]  total, remain, halfPoint, movedNext;
  logic [DATA_W-1:0] dataReg, widthMask;
  logic [ADDR_W-1:0] stepSize;
  logic [1:0]        latWidth, latPrio;
  logic              latSrcInc, latDstInc;

  always_comb begin
    case (latWidth)
      WID_BYTE: begin stepSize = ADDR_W'(1); widthMask = DATA_W'(8'hFF);    end
      WID_HALF: begin stepSize = ADDR_W'(2); widthMask = DATA_W'(16'hFFFF); end
      default:  begin stepSize = ADDR_W'(4); widthMask = '1;                end
    endcase
  end

  assign halfPoint = total >> 1;
  assign movedNext = total - remain + ONE_CNT;
  assign halfHit   = (halfPoint != '0) && (movedNext == halfPoint);
  assign lastItem  = (remain == ONE_CNT);

  // configuration latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseSrc   <= '0;
      baseDst   <= '0;
      total     <= '0;
      latWidth  <= WID_BYTE;
      latDir    <= DIR_P2M;
      latSrcInc <= 1'b0;
      latDstInc <= 1'b0;
      latCirc   <= 1'b0;
      latChan   <= '0;
      latPrio   <= '0;
    end else if (strb.load) begin
      baseSrc   <= cfgSrcAddr;
      baseDst   <= cfgDstAddr;
      total     <= cfgCount;
      latWidth  <= cfgWidth;
      latDir    <= cfgDir;
      latSrcInc <= cfgSrcInc;
      latDstInc <= cfgDstInc;
      latCirc   <= cfgCircular;
      latChan   <= cfgChanSel;
      latPrio   <= cfgPriority;
    end
  end

  // running addresses and item count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrc <= '0;
      curDst <= '0;
      remain <= '0;
    end else if (strb.load) begin
      curSrc <= cfgSrcAddr;
      curDst <= cfgDstAddr;
      remain <= cfgCount;
    end else if (strb.reload) begin
      curSrc <= baseSrc;
      curDst <= baseDst;
      remain <= total;
    end else if (strb.advance) begin
      if (latSrcInc) curSrc <= curSrc + stepSize;
      if (latDstInc) curDst <= curDst + stepSize;
      remain <= remain - ONE_CNT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataReg <= '0;
    else if (strb.capture) dataReg <= busRdata & widthMask;
  end

  assign busAddr     = strb.useDst ? curDst : curSrc;
  assign busWdata    = dataReg;
  assign busSize     = latWidth;
  assign busPriority = latPrio;

endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       halt,
  input  logic       countNonZero,
  input  logic       reqSel,
  input  logic [1:0] latDir,
  input  logic       latCirc,
  input  logic       lastItem,
  input  logic       halfHit,
  input  logic       busReady,
  input  logic       busErr,
  input  logic [2:0] clearFlags,
  output ctlStrobesT strb,
  output logic       busValid,
  output logic       busWrite,
  output logic       busy,
  output logic       halfFlag,
  output logic       doneFlag,
  output logic       errFlag
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

  streamStateE state, nextState;
  logic enable, enClr;
  logic [PEND_W-1:0] pending;
  logic isM2m, reqHit, takeReq;
  logic halfSet, doneSet, errSet;

  assign isM2m  = latDir[1];
  assign reqHit = reqSel && enable && !isM2m && (state != ST_IDLE) && (pending != PEND_MAX);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    strb      = '0;
    busValid  = 1'b0;
    busWrite  = 1'b0;
    nextState = state;
    takeReq   = 1'b0;
    enClr     = 1'b0;
    halfSet   = 1'b0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start && countNonZero) begin
          strb.load = 1'b1;
          nextState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!enable) begin
          nextState = ST_IDLE;
        end else if (isM2m || (pending != '0)) begin
          takeReq   = !isM2m;
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        busValid = 1'b1;
        if (busReady) begin
          if (busErr) begin
            errSet    = 1'b1;
            enClr     = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strb.capture = 1'b1;
            nextState    = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        busValid    = 1'b1;
        busWrite    = 1'b1;
        strb.useDst = 1'b1;
        if (busReady) begin
          if (busErr) begin
            errSet    = 1'b1;
            enClr     = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            halfSet      = halfHit;
            nextState    = ST_WAIT;
            if (lastItem) begin
              doneSet = 1'b1;
              if (latCirc) begin
                strb.reload = 1'b1;
              end else begin
                enClr     = 1'b1;
                nextState = ST_IDLE;
              end
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      enable <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.load)          enable <= 1'b1;
      else if (enClr || halt) enable <= 1'b0;
    end
  end

  // pending request counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else if (strb.load) begin
      pending <= '0;
    end else begin
      case ({reqHit, takeReq})
        2'b10:   pending <= pending + PEND_ONE;
        2'b01:   pending <= pending - PEND_ONE;
        default: pending <= pending;
      endcase
    end
  end

  // sticky flags with write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfFlag <= 1'b0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      halfFlag <= halfSet || (halfFlag && !clearFlags[0]);
      doneFlag <= doneSet || (doneFlag && !clearFlags[1]);
      errFlag  <= errSet  || (errFlag  && !clearFlags[2]);
    end
  end

endmodule

// File: rtl/dmaStream.sv
module dmaStream
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 8,
  parameter int PEND_W = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              halt,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [1:0]        cfgWidth,
  input  logic [1:0]        cfgDir,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic              cfgCircular,
  input  logic [CH_W-1:0]   cfgChanSel,
  input  logic [1:0]        cfgPriority,
  input  logic [NUM_CH-1:0] periphReq,
  input  logic [2:0]        clearFlags,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [1:0]        busSize,
  output logic [1:0]        busPriority,
  input  logic              busReady,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busErr,
  output logic              busy,
  output logic              halfFlag,
  output logic              doneFlag,
  output logic              errFlag
);

  ctlStrobesT      strb;
  logic [1:0]      latDir;
  logic            latCirc, lastItem, halfHit, reqSel;
  logic [CH_W-1:0] latChan;

  dmaReqMux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_reqMux (
    .reqLines (periphReq),
    .chanSel  (latChan),
    .reqSel   (reqSel)
  );

  dmaCtrl #(.PEND_W(PEND_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .halt         (halt),
    .countNonZero (cfgCount != '0),
    .reqSel       (reqSel),
    .latDir       (latDir),
    .latCirc      (latCirc),
    .lastItem     (lastItem),
    .halfHit      (halfHit),
    .busReady     (busReady),
    .busErr       (busErr),
    .clearFlags   (clearFlags),
    .strb         (strb),
    .busValid     (busValid),
    .busWrite     (busWrite),
    .busy         (busy),
    .halfFlag     (halfFlag),
    .doneFlag     (doneFlag),
    .errFlag      (errFlag)
  );

  dmaDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CH_W(CH_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgSrcAddr  (cfgSrcAddr),
    .cfgDstAddr  (cfgDstAddr),
    .cfgCount    (cfgCount),
    .cfgWidth    (cfgWidth),
    .cfgDir      (cfgDir),
    .cfgSrcInc   (cfgSrcInc),
    .cfgDstInc   (cfgDstInc),
    .cfgCircular (cfgCircular),
    .cfgChanSel  (cfgChanSel),
    .cfgPriority (cfgPriority),
    .busRdata    (busRdata),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busSize     (busSize),
    .busPriority (busPriority),
    .latDir      (latDir),
    .latCirc     (latCirc),
    .latChan     (latChan),
    .lastItem    (lastItem),
    .halfHit     (halfHit)
  );

endmodule

// File: rtl/dmaStreamChecker.sv
module dmaStreamChecker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [1:0]        busSize,
  input logic              busReady,
  input logic              busErr,
  input logic              busy,
  input logic              halfFlag,
  input logic              doneFlag,
  input logic              errFlag,
  input logic [2:0]        clearFlags
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busValid); // R1

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busAddr) && $stable(busWrite)); // R12

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && !busReady |=> $stable(busWdata)); // R12

  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busReady && busErr |=> !busValid && !busy && errFlag); // R10

  AST_BYTE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && (busSize == 2'd0) |-> (busWdata[DATA_W-1:8] == '0)); // R6

  AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halfFlag && !clearFlags[0] |=> halfFlag); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !clearFlags[1] |=> doneFlag); // R11

endmodule

bind dmaStream dmaStreamChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busSize    (busSize),
  .busReady   (busReady),
  .busErr     (busErr),
  .busy       (busy),
  .halfFlag   (halfFlag),
  .doneFlag   (doneFlag),
  .errFlag    (errFlag),
  .clearFlags (clearFlags)
);

// File: tb/test_dmaStream.sv
`timescale 1ns/1ps
module test_dmaStream;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN, start, halt;
  logic [ADDR_W-1:0] cfgSrcAddr, cfgDstAddr;
  logic [CNT_W-1:0]  cfgCount;
  logic [1:0]        cfgWidth, cfgDir, cfgPriority;
  logic              cfgSrcInc, cfgDstInc, cfgCircular;
  logic [CH_W-1:0]   cfgChanSel;
  logic [NUM_CH-1:0] periphReq;
  logic [2:0]        clearFlags;
  logic              busValid, busWrite, busReady, busErr;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busWdata, busRdata;
  logic [1:0]        busSize, busPriority;
  logic              busy, halfFlag, doneFlag, errFlag;

  dmaStream i_dmaStream (
    .clk(clk), .rstN(rstN), .start(start), .halt(halt),
    .cfgSrcAddr(cfgSrcAddr), .cfgDstAddr(cfgDstAddr), .cfgCount(cfgCount),
    .cfgWidth(cfgWidth), .cfgDir(cfgDir), .cfgSrcInc(cfgSrcInc), .cfgDstInc(cfgDstInc),
    .cfgCircular(cfgCircular), .cfgChanSel(cfgChanSel), .cfgPriority(cfgPriority),
    .periphReq(periphReq), .clearFlags(clearFlags),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busSize(busSize), .busPriority(busPriority), .busReady(busReady),
    .busRdata(busRdata), .busErr(busErr),
    .busy(busy), .halfFlag(halfFlag), .doneFlag(doneFlag), .errFlag(errFlag)
  );

  int checks = 0;
  int errors = 0;
  int holdViol = 0;
  logic [ADDR_W-1:0] wAddrQ[$];
  logic [ADDR_W-1:0] rAddrQ[$];
  logic [DATA_W-1:0] wDataQ[$];
  logic [1:0]        wSizeQ[$];
  logic              errArm = 1'b0;
  logic [ADDR_W-1:0] errAddr = '0;

  function automatic logic [31:0] hashOf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] maskOf(input logic [1:0] w);
    return (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] addrOf(input logic [31:0] base, input logic inc,
                                         input logic [1:0] w, input int idx);
    logic [31:0] step;
    step = (w == 2'd0) ? 32'd1 : (w == 2'd1) ? 32'd2 : 32'd4;
    return inc ? base + step * 32'(idx) : base;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // bus responder with random wait states
  initial begin
    logic prevStall;
    logic [ADDR_W-1:0] prevAddr;
    prevStall = 1'b0;
    prevAddr  = '0;
    busReady = 1'b0; busRdata = '0; busErr = 1'b0;
    forever begin
      @(negedge clk);
      if (prevStall && (!busValid || busAddr != prevAddr)) holdViol++;
      if (busValid && ($urandom % 4 != 0)) begin
        busReady  = 1'b1;
        busRdata  = hashOf(busAddr);
        busErr    = errArm && !busWrite && (busAddr == errAddr);
        if (busErr) errArm = 1'b0;
        if (busWrite) begin
          wAddrQ.push_back(busAddr);
          wDataQ.push_back(busWdata);
          wSizeQ.push_back(busSize);
        end else begin
          rAddrQ.push_back(busAddr);
        end
        prevStall = 1'b0;
      end else begin
        busReady  = 1'b0;
        busErr    = 1'b0;
        busRdata  = $urandom;
        prevStall = busValid;
        prevAddr  = busAddr;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  task automatic clearLogs();
    wAddrQ.delete(); rAddrQ.delete(); wDataQ.delete(); wSizeQ.delete();
  endtask

  task automatic setCfg(input logic [31:0] src, input logic [31:0] dst, input int n,
                        input logic [1:0] w, input logic [1:0] dir, input logic si,
                        input logic di, input logic circ, input int ch, input logic [1:0] prio);
    cfgSrcAddr = src; cfgDstAddr = dst; cfgCount = CNT_W'(n);
    cfgWidth = w; cfgDir = dir; cfgSrcInc = si; cfgDstInc = di;
    cfgCircular = circ; cfgChanSel = CH_W'(ch); cfgPriority = prio;
  endtask

  task automatic go();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulseReq(input int ch);
    @(negedge clk) periphReq[ch] = 1'b1;
    @(negedge clk) periphReq = '0;
  endtask

  task automatic pulseClear(input logic [2:0] bits);
    @(negedge clk) clearFlags = bits;
    @(negedge clk) clearFlags = '0;
    @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int t = 0; t < 4000 && busy; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitWrites(input int n);
    for (int t = 0; t < 4000 && wAddrQ.size() < n; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkItems(input string req, input int n, input int total);
    for (int k = 0; k < n && k < wAddrQ.size(); k++) begin
      int idx;
      logic [31:0] eSrc, eDst;
      idx  = cfgCircular ? k % total : k;
      eSrc = addrOf(cfgSrcAddr, cfgSrcInc, cfgWidth, idx);
      eDst = addrOf(cfgDstAddr, cfgDstInc, cfgWidth, idx);
      check(rAddrQ[k] == eSrc, req, "read address", rAddrQ[k], eSrc);
      check(wAddrQ[k] == eDst, req, "write address", wAddrQ[k], eDst);
      check(wDataQ[k] == (hashOf(eSrc) & maskOf(cfgWidth)), "R6", "write data",
            wDataQ[k], hashOf(eSrc) & maskOf(cfgWidth));
      check(wSizeQ[k] == cfgWidth, "R6", "beat size", 32'(wSizeQ[k]), 32'(cfgWidth));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; start = 1'b0; halt = 1'b0; periphReq = '0; clearFlags = '0;
    setCfg(32'h0, 32'h0, 0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 0, 2'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({busy, halfFlag, doneFlag, errFlag, busValid} == 5'b0, "R1", "reset outputs",
          32'({busy, halfFlag, doneFlag, errFlag, busValid}), 32'h0);

    // R2 zero count is ignored
    clearLogs();
    setCfg(32'h100, 32'h200, 0, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 0, 2'd1);
    go();
    repeat (4) @(negedge clk);
    check(!busy, "R2", "busy after zero-count start", 32'(busy), 32'h0);
    check(rAddrQ.size() == 0, "R2", "beats after zero-count start", rAddrQ.size(), 32'h0);

    // R3 R7 R4 directed half-transfer and channel select
    clearLogs();
    setCfg(32'h3000, 32'h4000, 5, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 3, 2'd2);
    go();
    pulseReq(0);
    pulseReq(5);
    repeat (10) @(negedge clk);
    check(rAddrQ.size() == 0, "R3", "beats from unselected lines", rAddrQ.size(), 32'h0);
    check(busy, "R2", "busy after start", 32'(busy), 32'h1);
    pulseReq(3);
    waitWrites(1);
    check(!halfFlag, "R7", "half flag after 1 of 5", 32'(halfFlag), 32'h0);
    pulseReq(3);
    waitWrites(2);
    check(halfFlag, "R7", "half flag after 2 of 5", 32'(halfFlag), 32'h1);
    check(!doneFlag, "R8", "done flag after 2 of 5", 32'(doneFlag), 32'h0);
    for (int r = 0; r < 3; r++) begin
      @(negedge clk) periphReq[3] = 1'b1;
    end
    @(negedge clk) periphReq = '0;
    waitIdle();
    check(wAddrQ.size() == 5, "R4", "items after back-to-back requests", wAddrQ.size(), 32'd5);
    check(doneFlag && !busy, "R8", "done and idle", 32'({doneFlag, busy}), 32'h2);
    checkItems("R5", 5, 5);
    pulseClear(3'b111);
    check({halfFlag, doneFlag, errFlag} == 3'b0, "R11", "flags after clear",
          32'({halfFlag, doneFlag, errFlag}), 32'h0);

    // R9 circular with wrap, then halt
    clearLogs();
    setCfg(32'h5000, 32'h6000, 3, 2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 6, 2'd3);
    go();
    check(busPriority == 2'd3, "R13", "latched priority", 32'(busPriority), 32'h3);
    for (int r = 0; r < 7; r++) begin
      @(negedge clk) periphReq[6] = 1'b1;
    end
    @(negedge clk) periphReq = '0;
    waitWrites(7);
    repeat (10) @(negedge clk);
    check(wAddrQ.size() == 7, "R9", "items over rounds", wAddrQ.size(), 32'd7);
    check(busy && doneFlag, "R9", "still running after wrap", 32'({busy, doneFlag}), 32'h3);
    checkItems("R9", 7, 3);
    @(negedge clk) halt = 1'b1;
    @(negedge clk) halt = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy, "R9", "busy after halt", 32'(busy), 32'h0);
    pulseClear(3'b111);

    // R10 read error mid transfer
    clearLogs();
    setCfg(32'h7000, 32'h7800, 4, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 0, 2'd0);
    errAddr = 32'h7008;
    errArm  = 1'b1;
    go();
    waitIdle();
    check(errFlag && !doneFlag && !busy, "R10", "error stop state",
          32'({errFlag, doneFlag, busy}), 32'h4);
    check(wAddrQ.size() == 2, "R10", "writes before error", wAddrQ.size(), 32'd2);
    check(rAddrQ.size() == 3, "R10", "reads including failed", rAddrQ.size(), 32'd3);
    repeat (20) @(negedge clk);
    check(rAddrQ.size() == 3, "R10", "reads after stop", rAddrQ.size(), 32'd3);
    checkItems("R10", 2, 4);
    pulseClear(3'b100);
    check(!errFlag && halfFlag, "R11", "selective clear", 32'({errFlag, halfFlag}), 32'h1);
    pulseClear(3'b111);

    // random transfers, R3 R4 R5 R6 R7 R8 R13
    for (int it = 0; it < 30; it++) begin
      int n, ch;
      logic [1:0] w, dir, prio;
      n = 1 + int'($urandom % 9);
      w = 2'($urandom % 3);
      dir = 2'($urandom % 3);
      ch = int'($urandom % NUM_CH);
      prio = 2'($urandom);
      clearLogs();
      setCfg(32'h1000 + ($urandom % 64) * 4, 32'h9000 + ($urandom % 64) * 4, n, w, dir,
             1'($urandom), 1'($urandom), 1'b0, ch, prio);
      go();
      check(busPriority == prio, "R13", "random priority", 32'(busPriority), 32'(prio));
      if (dir != 2'd2) begin
        for (int r = 0; r < n; r++) begin
          repeat ($urandom % 4) @(negedge clk);
          if ($urandom % 3 == 0) pulseReq((ch + 1) % NUM_CH);
          pulseReq(ch);
        end
      end
      waitIdle();
      check(!busy && doneFlag, "R8", "random done", 32'({busy, doneFlag}), 32'h1);
      check(halfFlag == (n >= 2), "R7", "random half", 32'(halfFlag), 32'(n >= 2));
      check(wAddrQ.size() == n, "R3", "random item count", wAddrQ.size(), 32'(n));
      checkItems("R5", n, n);
      pulseClear(3'b111);
    end

    check(holdViol == 0, "R12", "stalled beat changed", holdViol, 32'h0);
    finishRun();
  end

endmodule